// File: doc/BRIEF.md
# Triggered Command Set Engine

This block holds a small bank of command sets behind a memory-mapped register port. Each set owns a row of command slots, and each slot stores a message-id word, a target address and a data word. Software fills the slots, selects which slots take part through a per-set slot-enable mask, and chooses which slots must see a completion through a per-set wait mask. It then arms the set and fires it with a two-step write to that set's control register.

A single sequencer serves the fired sets one at a time, lowest set index first. It walks the slots in ascending order and sends each enabled command over a valid/ready output port. After a slot that has its wait bit set, the sequencer holds until the downstream side returns a completion strobe. Each slot records whether it was issued and whether its completion returned, and it captures a response word. When a set has walked its last slot, the set goes idle again and, if its interrupt is enabled, latches a done flag that drives the interrupt line until software clears it.

Top module: `cmdset_engine`

## Requirements
- R1: Set s occupies the byte window starting at s*672. Within a window: offset 0x10 wait mask, 0x14 control, 0x18 status, 0x1C slot-enable mask. Slot k's registers start at 0x30 + k*20 and hold message id (+0x0), address (+0x4), data (+0x8), slot status (+0xC) and response word (+0x10). Interrupt enable (0x00), interrupt status (0x04) and interrupt clear (0x08) exist only in set 0's window. Every other offset reads 0.
- R2: After reset, all control, mask, slot-status and interrupt registers read 0, every set's status register reads 1, and irq_o is low.
- R3: Control bit 16 is the arm bit and bit 24 is the fire bit. A fire write starts a run and is stored only if the arm bit was already 1 before that write. A write that sets both bits together when the set is not yet armed records the arm bit only and sends nothing.
- R4: A control write that clears bit 16 while bit 24 is stored set clears bit 24 only. The arm bit can be dropped only by a later write, once the fire bit is clear.
- R5: While a set is busy, writes to its control register are ignored, and a new fire has no effect.
- R6: During a run, only slots whose slot-enable bit is 1 are sent, in ascending slot order. Each command carries the slot's message-id, address and data words unchanged, together with the set index on cmd_set_o.
- R7: While cmd_valid_o is high and cmd_ready_i is low, cmd_valid_o and all command fields stay unchanged.
- R8: After a slot whose wait-mask bit is 1 is accepted, no further command is sent until cmd_done_i has been seen. Slots without the wait bit are not waited on.
- R9: In the slot status word, bit 8 is set when the slot's command is accepted. Bit 16 is set, and cmd_resp_i is captured into the response word, when cmd_done_i arrives for that slot. Both bits of every slot in a set are cleared when that set is fired again.
- R10: A set's status register reads 1 when idle and 0 from the fire write until the set's last slot has been walked, including while the set waits behind another set.
- R11: When a run finishes, interrupt status bit s is set only if interrupt enable bit s is 1. Writing 1 to bit s of the clear register clears that bit. irq_o is the OR of all interrupt status bits.
- R12: When several sets have been fired, the lowest-index set is served next. A running set is never preempted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 32 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as the read strobe |
| cmd_valid_o | output | 1 | Command offered downstream |
| cmd_ready_i | input | 1 | Downstream accepts the command |
| cmd_set_o | output | 2 | Set index of the offered command |
| cmd_msgid_o | output | 32 | Message-id word of the offered command |
| cmd_addr_o | output | 32 | Address word of the offered command |
| cmd_data_o | output | 32 | Data word of the offered command |
| cmd_done_i | input | 1 | Completion strobe for the slot being waited on |
| cmd_resp_i | input | 32 | Response word sampled with cmd_done_i |
| irq_o | output | 1 | Interrupt, OR of the interrupt status bits |

## Verification
The bench fires a set whose enabled slots are scattered and include the last slot. A design that stopped early, sent disabled slots or reordered them would leave the scoreboard queue non-empty or produce a mismatch. It fires two sets while a third is stalled mid-run and checks that they are served in ascending set order rather than in the order they were fired. It also rewrites the control register of the stalled set, and a design that accepted that write would show a changed readback or send extra commands. The arm/fire handshake is tested with a combined write from the unarmed state and with a disarm attempt while the fire bit is set, which expose a fire that skips the arm check or a one-step disarm. The completion path is tested with a wait slot followed by more traffic: an early next command, a missing completion bit, a stale response word, or status bits that survive a re-fire all show up in the slot readbacks.

// File: rtl/cmdset_pkg.sv
package cmdset_pkg;
  // byte strides and offsets; software decodes these, so they are fixed
  localparam int SET_STRIDE  = 672;
  localparam int SLOT_STRIDE = 20;
  localparam int CMD_BASE    = 'h30;

  localparam int OFF_IRQ_EN  = 'h00;
  localparam int OFF_IRQ_STS = 'h04;
  localparam int OFF_IRQ_CLR = 'h08;
  localparam int OFF_WAIT    = 'h10;
  localparam int OFF_CTRL    = 'h14;
  localparam int OFF_STAT    = 'h18;
  localparam int OFF_CMD_EN  = 'h1C;

  localparam int FLD_MSGID = 'h0;
  localparam int FLD_ADDR  = 'h4;
  localparam int FLD_DATA  = 'h8;
  localparam int FLD_STS   = 'hC;
  localparam int FLD_RESP  = 'h10;

  localparam int CTRL_ARM_BIT   = 16;
  localparam int CTRL_FIRE_BIT  = 24;
  localparam int STS_ISSUED_BIT = 8;
  localparam int STS_COMPL_BIT  = 16;

  typedef enum logic [1:0] {SQ_IDLE, SQ_SCAN, SQ_SEND, SQ_WAIT} seq_state_e;
endpackage

// File: rtl/cmdset_ctrl.sv
module cmdset_ctrl
  import cmdset_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        wr_arm_i,
  input  logic        wr_fire_i,
  input  logic        fin_i,
  output logic [31:0] ctrl_o,
  output logic        fire_o,
  output logic        busy_o
);
  logic arm_q, fire_q, busy_q;

  assign fire_o = wr_i && !busy_q && wr_fire_i && arm_q && !fire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= 1'b0;
      fire_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (wr_i && !busy_q) begin
        fire_q <= wr_fire_i & arm_q;
        arm_q  <= wr_arm_i | fire_q;   // arm drops only once fire is clear
      end
      if (fire_o)     busy_q <= 1'b1;
      else if (fin_i) busy_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_o = '0;
    ctrl_o[CTRL_ARM_BIT]  = arm_q;
    ctrl_o[CTRL_FIRE_BIT] = fire_q;
  end
  assign busy_o = busy_q;

  assert_fire_needs_arm_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(arm_q));
  assert_disarm_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(arm_q) |-> $past(!fire_q));
  assert_busy_locks_ctrl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable({arm_q, fire_q}));
endmodule

// File: rtl/cmdset_seq.sv
module cmdset_seq
  import cmdset_pkg::*;
#(
  parameter int NUM_SETS  = 4,
  parameter int NUM_SLOTS = 16,
  localparam int SET_W  = (NUM_SETS  > 1) ? $clog2(NUM_SETS)  : 1,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_SETS-1:0]                 pend_i,
  input  logic [NUM_SETS-1:0][NUM_SLOTS-1:0]  en_mask_i,
  input  logic [NUM_SETS-1:0][NUM_SLOTS-1:0]  wait_mask_i,
  input  logic                                cmd_ready_i,
  input  logic                                cmd_done_i,
  output logic                                valid_o,
  output logic [SET_W-1:0]                    set_o,
  output logic [SLOT_W-1:0]                   slot_o,
  output logic                                issue_o,
  output logic                                compl_o,
  output logic                                fin_o
);
  seq_state_e        state_q;
  logic [SET_W-1:0]  set_q, pick;
  logic [SLOT_W-1:0] slot_q;
  logic              last, advance;

  assign last = (slot_q == SLOT_W'(NUM_SLOTS - 1));

  always_comb begin
    pick = '0;
    for (int s = NUM_SETS - 1; s >= 0; s--)
      if (pend_i[s]) pick = SET_W'(s);
  end

  always_comb begin
    advance = 1'b0;
    case (state_q)
      SQ_SCAN: advance = !en_mask_i[set_q][slot_q];
      SQ_SEND: advance = cmd_ready_i && !wait_mask_i[set_q][slot_q];
      SQ_WAIT: advance = cmd_done_i;
      default: advance = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      set_q   <= '0;
      slot_q  <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: if (|pend_i) begin
          set_q   <= pick;
          slot_q  <= '0;
          state_q <= SQ_SCAN;
        end
        SQ_SCAN: if (en_mask_i[set_q][slot_q]) state_q <= SQ_SEND;
        SQ_SEND: if (cmd_ready_i && wait_mask_i[set_q][slot_q]) state_q <= SQ_WAIT;
        default: ;
      endcase
      if (advance) begin
        if (last) state_q <= SQ_IDLE;
        else begin
          slot_q  <= slot_q + SLOT_W'(1);
          state_q <= SQ_SCAN;
        end
      end
    end
  end

  assign valid_o = (state_q == SQ_SEND);
  assign issue_o = valid_o && cmd_ready_i;
  assign compl_o = (state_q == SQ_WAIT) && cmd_done_i;
  assign fin_o   = advance && last;
  assign set_o   = set_q;
  assign slot_o  = slot_q;

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !cmd_ready_i |=> valid_o && $stable(set_q) && $stable(slot_q));
  assert_enabled_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(en_mask_i[set_q][slot_q]));
  assert_wait_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o && wait_mask_i[set_q][slot_q] |=> !valid_o);
endmodule

// File: rtl/cmdset_engine.sv
module cmdset_engine
  import cmdset_pkg::*;
#(
  parameter int NUM_SETS  = 4,
  parameter int NUM_SLOTS = 16,
  localparam int SET_W  = (NUM_SETS  > 1) ? $clog2(NUM_SETS)  : 1,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_en_i,
  input  logic             bus_we_i,
  input  logic [31:0]      bus_addr_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  output logic             cmd_valid_o,
  input  logic             cmd_ready_i,
  output logic [SET_W-1:0] cmd_set_o,
  output logic [31:0]      cmd_msgid_o,
  output logic [31:0]      cmd_addr_o,
  output logic [31:0]      cmd_data_o,
  input  logic             cmd_done_i,
  input  logic [31:0]      cmd_resp_i,
  output logic             irq_o
);
  // address decode
  logic              dec_hit, dec_cmd;
  logic [SET_W-1:0]  dec_set;
  logic [SLOT_W-1:0] dec_slot;
  logic [31:0]       dec_off, dec_fld;

  always_comb begin
    dec_hit = 1'b0; dec_cmd = 1'b0; dec_set = '0; dec_slot = '0;
    dec_off = '0;   dec_fld = '0;
    for (int s = 0; s < NUM_SETS; s++)
      if (bus_addr_i >= 32'(s * SET_STRIDE) && bus_addr_i < 32'((s + 1) * SET_STRIDE)) begin
        dec_hit = 1'b1;
        dec_set = SET_W'(s);
        dec_off = bus_addr_i - 32'(s * SET_STRIDE);
      end
    for (int k = 0; k < NUM_SLOTS; k++)
      if (dec_off >= 32'(CMD_BASE + k * SLOT_STRIDE) &&
          dec_off <  32'(CMD_BASE + (k + 1) * SLOT_STRIDE)) begin
        dec_cmd  = dec_hit;
        dec_slot = SLOT_W'(k);
        dec_fld  = dec_off - 32'(CMD_BASE + k * SLOT_STRIDE);
      end
  end

  logic wr, wr_reg, set0;
  assign wr     = bus_en_i && bus_we_i && dec_hit;
  assign wr_reg = wr && !dec_cmd;
  assign set0   = (dec_set == '0);

  // register file
  logic [NUM_SETS-1:0][NUM_SLOTS-1:0] en_mask_q, wait_mask_q, issued_q, compl_q;
  logic [31:0] msgid_q [NUM_SETS][NUM_SLOTS];
  logic [31:0] addr_q  [NUM_SETS][NUM_SLOTS];
  logic [31:0] data_q  [NUM_SETS][NUM_SLOTS];
  logic [31:0] resp_q  [NUM_SETS][NUM_SLOTS];
  logic [NUM_SETS-1:0] irq_en_q, irq_sts_q;

  // per-set control and sequencer
  logic [NUM_SETS-1:0] fire, busy, wr_ctrl, set_fin;
  logic [31:0]         ctrl_w [NUM_SETS];
  logic                seq_issue, seq_compl, seq_fin;
  logic [SET_W-1:0]    seq_set;
  logic [SLOT_W-1:0]   seq_slot;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    assign wr_ctrl[s] = wr_reg && (dec_off == 32'(OFF_CTRL)) && (dec_set == SET_W'(s));
    assign set_fin[s] = seq_fin && (seq_set == SET_W'(s));
    cmdset_ctrl u_ctrl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_ctrl[s]),
      .wr_arm_i  (bus_wdata_i[CTRL_ARM_BIT]),
      .wr_fire_i (bus_wdata_i[CTRL_FIRE_BIT]),
      .fin_i     (set_fin[s]),
      .ctrl_o    (ctrl_w[s]),
      .fire_o    (fire[s]),
      .busy_o    (busy[s])
    );
  end

  cmdset_seq #(.NUM_SETS(NUM_SETS), .NUM_SLOTS(NUM_SLOTS)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pend_i      (busy),
    .en_mask_i   (en_mask_q),
    .wait_mask_i (wait_mask_q),
    .cmd_ready_i (cmd_ready_i),
    .cmd_done_i  (cmd_done_i),
    .valid_o     (cmd_valid_o),
    .set_o       (seq_set),
    .slot_o      (seq_slot),
    .issue_o     (seq_issue),
    .compl_o     (seq_compl),
    .fin_o       (seq_fin)
  );

  assign cmd_set_o   = seq_set;
  assign cmd_msgid_o = msgid_q[seq_set][seq_slot];
  assign cmd_addr_o  = addr_q[seq_set][seq_slot];
  assign cmd_data_o  = data_q[seq_set][seq_slot];
  assign irq_o       = |irq_sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_mask_q <= '0; wait_mask_q <= '0; issued_q <= '0; compl_q <= '0;
      irq_en_q  <= '0; irq_sts_q   <= '0;
      for (int s = 0; s < NUM_SETS; s++)
        for (int k = 0; k < NUM_SLOTS; k++) begin
          msgid_q[s][k] <= '0; addr_q[s][k] <= '0;
          data_q[s][k]  <= '0; resp_q[s][k] <= '0;
        end
    end else begin
      if (wr_reg) begin
        case (dec_off)
          32'(OFF_WAIT):   wait_mask_q[dec_set] <= bus_wdata_i[NUM_SLOTS-1:0];
          32'(OFF_CMD_EN): en_mask_q[dec_set]   <= bus_wdata_i[NUM_SLOTS-1:0];
          32'(OFF_IRQ_EN): if (set0) irq_en_q   <= bus_wdata_i[NUM_SETS-1:0];
          default: ;
        endcase
      end
      if (wr && dec_cmd) begin
        case (dec_fld)
          32'(FLD_MSGID): msgid_q[dec_set][dec_slot] <= bus_wdata_i;
          32'(FLD_ADDR):  addr_q[dec_set][dec_slot]  <= bus_wdata_i;
          32'(FLD_DATA):  data_q[dec_set][dec_slot]  <= bus_wdata_i;
          default: ;
        endcase
      end
      for (int s = 0; s < NUM_SETS; s++) begin
        if (fire[s]) begin
          issued_q[s] <= '0;
          compl_q[s]  <= '0;
        end
        if (set_fin[s] && irq_en_q[s]) irq_sts_q[s] <= 1'b1;
        else if (wr_reg && set0 && dec_off == 32'(OFF_IRQ_CLR) && bus_wdata_i[s])
          irq_sts_q[s] <= 1'b0;
      end
      if (seq_issue) issued_q[seq_set][seq_slot] <= 1'b1;
      if (seq_compl) begin
        compl_q[seq_set][seq_slot] <= 1'b1;
        resp_q[seq_set][seq_slot]  <= cmd_resp_i;
      end
    end
  end

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    if (bus_en_i && !bus_we_i && dec_hit) begin
      if (dec_cmd) begin
        case (dec_fld)
          32'(FLD_MSGID): bus_rdata_o = msgid_q[dec_set][dec_slot];
          32'(FLD_ADDR):  bus_rdata_o = addr_q[dec_set][dec_slot];
          32'(FLD_DATA):  bus_rdata_o = data_q[dec_set][dec_slot];
          32'(FLD_RESP):  bus_rdata_o = resp_q[dec_set][dec_slot];
          32'(FLD_STS): begin
            bus_rdata_o[STS_ISSUED_BIT] = issued_q[dec_set][dec_slot];
            bus_rdata_o[STS_COMPL_BIT]  = compl_q[dec_set][dec_slot];
          end
          default: ;
        endcase
      end else begin
        case (dec_off)
          32'(OFF_IRQ_EN):  if (set0) bus_rdata_o = 32'(irq_en_q);
          32'(OFF_IRQ_STS): if (set0) bus_rdata_o = 32'(irq_sts_q);
          32'(OFF_WAIT):    bus_rdata_o = 32'(wait_mask_q[dec_set]);
          32'(OFF_CMD_EN):  bus_rdata_o = 32'(en_mask_q[dec_set]);
          32'(OFF_CTRL):    bus_rdata_o = ctrl_w[dec_set];
          32'(OFF_STAT):    bus_rdata_o = {31'b0, !busy[dec_set]};
          default: ;
        endcase
      end
    end
  end

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_irq_chk
    assert_irq_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_sts_q[s]) |-> $past(irq_en_q[s]));
  end
  assert_irq_line_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(seq_fin));
endmodule

// File: tb/cmdset_engine_test.sv
module cmdset_engine_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_en_i = 1'b0, bus_we_i = 1'b0;
  logic [31:0] bus_addr_i = '0, bus_wdata_i = '0, bus_rdata_o;
  logic        cmd_valid_o, cmd_ready_i = 1'b0, cmd_done_i = 1'b0, irq_o;
  logic [1:0]  cmd_set_o;
  logic [31:0] cmd_msgid_o, cmd_addr_o, cmd_data_o, cmd_resp_i = '0;

  always #2 clk_i = ~clk_i;

  cmdset_engine uut (.*);

  typedef struct packed {logic [1:0] s; logic [31:0] m, a, d;} exp_t;
  exp_t exp_q[$];
  int checks = 0, errors = 0, hs_count = 0;
  bit hold_ready = 1'b0, waiting = 1'b0, prev_stall = 1'b0;
  int wait_cnt = 0, rdy_cnt = 0;
  logic [31:0] resp_val = '0;
  exp_t prev_cmd;

  function automatic logic [31:0] reg_a(int s, int off); return 32'(s * 672 + off); endfunction
  function automatic logic [31:0] slot_a(int s, int k, int f); return 32'(s * 672 + 'h30 + k * 20 + f); endfunction
  function automatic logic [31:0] msgid_of(bit w); return 32'h0001_0008 | (w ? 32'h100 : 32'h0); endfunction
  function automatic logic [31:0] addr_of(int s, int k); return 32'h1000 + 32'(s * 256 + k); endfunction
  function automatic logic [31:0] data_of(int s, int k); return 32'hD000_0000 + 32'(s * 65536 + k * 17); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk_i);
    bus_en_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_en_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic bus_rd(logic [31:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_en_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    bus_en_i = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [31:0] a, logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic program_set(int s, logic [15:0] en, logic [15:0] wt);
    for (int k = 0; k < 16; k++)
      if (en[k]) begin
        bus_wr(slot_a(s, k, 'h0), msgid_of(wt[k]));
        bus_wr(slot_a(s, k, 'h4), addr_of(s, k));
        bus_wr(slot_a(s, k, 'h8), data_of(s, k));
      end
    bus_wr(reg_a(s, 'h10), 32'(wt));
    bus_wr(reg_a(s, 'h1C), 32'(en));
  endtask

  task automatic push_exp(int s, logic [15:0] en, logic [15:0] wt);
    for (int k = 0; k < 16; k++)
      if (en[k]) exp_q.push_back({2'(s), msgid_of(wt[k]), addr_of(s, k), data_of(s, k)});
  endtask

  task automatic wait_idle(int s);
    logic [31:0] d = '0;
    for (int i = 0; i < 3000 && d == 0; i++) bus_rd(reg_a(s, 'h18), d);
    chk("R10 set returns idle", d, 32'h1);
  endtask

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // responder and scoreboard monitor
  always @(negedge clk_i) begin
    if (cmd_done_i) cmd_done_i = 1'b0;
    if (wait_cnt != 0) begin
      wait_cnt--;
      if (wait_cnt == 0) begin
        cmd_done_i = 1'b1; cmd_resp_i = resp_val; waiting = 1'b0;
      end
    end
    if (prev_stall) begin
      checks++;
      if (!cmd_valid_o || {cmd_set_o, cmd_msgid_o, cmd_addr_o, cmd_data_o} !== prev_cmd) begin
        errors++;
        $display("FAIL R7 held command changed: actual %h expected %h",
                 {cmd_set_o, cmd_msgid_o, cmd_addr_o, cmd_data_o}, prev_cmd);
      end
    end
    rdy_cnt++;
    cmd_ready_i = !hold_ready && (rdy_cnt % 3 != 1);
    prev_stall = cmd_valid_o && !cmd_ready_i;
    prev_cmd = {cmd_set_o, cmd_msgid_o, cmd_addr_o, cmd_data_o};
    if (cmd_valid_o && cmd_ready_i) begin
      exp_t e;
      hs_count++;
      checks++;
      if (waiting) begin
        errors++;
        $display("FAIL R8 command sent before completion: actual %h expected none", cmd_addr_o);
      end
      if (exp_q.size() == 0) begin
        errors++; checks++;
        $display("FAIL R6 unexpected command: actual %h expected none", cmd_addr_o);
      end else begin
        e = exp_q.pop_front();
        chk("R6 R12 command order and content", {30'b0, cmd_set_o}, {30'b0, e.s});
        chk("R6 message id", cmd_msgid_o, e.m);
        chk("R6 address", cmd_addr_o, e.a);
        chk("R6 data", cmd_data_o, e.d);
      end
      if (cmd_msgid_o[8]) begin
        waiting = 1'b1; wait_cnt = 3; resp_val = cmd_data_o ^ 32'h5A5A_0000;
      end
    end
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int hs_before;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R2 reset state, R1 unmapped offsets
    chk("R2 irq low after reset", {31'b0, irq_o}, 32'h0);
    rd_chk("R2 ctrl reset", reg_a(0, 'h14), 32'h0);
    rd_chk("R2 status idle", reg_a(2, 'h18), 32'h1);
    rd_chk("R2 slot enable reset", reg_a(3, 'h1C), 32'h0);
    rd_chk("R2 wait mask reset", reg_a(1, 'h10), 32'h0);
    rd_chk("R2 slot status reset", slot_a(0, 4, 'hC), 32'h0);
    rd_chk("R1 unmapped offset", reg_a(1, 'h20), 32'h0);

    // main run on set 0 with a wait slot
    bus_wr(reg_a(0, 'h00), 32'h5);
    rd_chk("R1 irq enable in set 0 window", reg_a(0, 'h00), 32'h5);
    rd_chk("R1 irq enable absent in set 1 window", reg_a(1, 'h00), 32'h0);
    program_set(0, 16'h8025, 16'h0004);
    rd_chk("R1 slot address readback", slot_a(0, 5, 'h4), addr_of(0, 5));
    rd_chk("R1 slot enable readback", reg_a(0, 'h1C), 32'h8025);
    push_exp(0, 16'h8025, 16'h0004);
    bus_wr(reg_a(0, 'h14), 32'h0001_0000);
    bus_wr(reg_a(0, 'h14), 32'h0101_0000);
    rd_chk("R10 busy after fire", reg_a(0, 'h18), 32'h0);
    wait_idle(0);
    chk("R6 all enabled slots sent", 32'(exp_q.size()), 32'h0);
    chk("R11 irq raised", {31'b0, irq_o}, 32'h1);
    rd_chk("R11 irq status", reg_a(0, 'h04), 32'h1);
    rd_chk("R9 wait slot issued and complete", slot_a(0, 2, 'hC), 32'h0001_0100);
    rd_chk("R9 plain slot issued only", slot_a(0, 0, 'hC), 32'h0000_0100);
    rd_chk("R9 disabled slot untouched", slot_a(0, 1, 'hC), 32'h0);
    rd_chk("R9 response captured", slot_a(0, 2, 'h10), data_of(0, 2) ^ 32'h5A5A_0000);

    bus_wr(reg_a(0, 'h08), 32'h1);
    rd_chk("R11 clear by write one", reg_a(0, 'h04), 32'h0);
    chk("R11 irq low after clear", {31'b0, irq_o}, 32'h0);

    // R3 combined arm+fire from unarmed
    hs_before = hs_count;
    program_set(1, 16'h0003, 16'h0000);
    bus_wr(reg_a(1, 'h14), 32'h0101_0000);
    rd_chk("R3 fire ignored when unarmed", reg_a(1, 'h14), 32'h0001_0000);
    rd_chk("R3 status stays idle", reg_a(1, 'h18), 32'h1);
    repeat (40) @(negedge clk_i);
    chk("R3 nothing sent", 32'(hs_count - hs_before), 32'h0);

    // R4 disarm order on set 0 (arm+fire stored)
    bus_wr(reg_a(0, 'h14), 32'h0);
    rd_chk("R4 first clear drops fire only", reg_a(0, 'h14), 32'h0001_0000);
    bus_wr(reg_a(0, 'h14), 32'h0);
    rd_chk("R4 second clear drops arm", reg_a(0, 'h14), 32'h0);

    // R11 run with interrupt disabled (set 1 already armed)
    push_exp(1, 16'h0003, 16'h0000);
    bus_wr(reg_a(1, 'h14), 32'h0101_0000);
    wait_idle(1);
    rd_chk("R11 no status when disabled", reg_a(0, 'h04), 32'h0);
    chk("R11 irq stays low", {31'b0, irq_o}, 32'h0);

    // R5, R12: stall set 3, fire 2 then 1
    hold_ready = 1'b1;
    program_set(3, 16'h0041, 16'h0001);
    program_set(2, 16'h0102, 16'h0000);
    bus_wr(slot_a(1, 7, 'h0), msgid_of(1'b0));
    bus_wr(slot_a(1, 7, 'h4), addr_of(1, 7));
    bus_wr(slot_a(1, 7, 'h8), data_of(1, 7));
    bus_wr(reg_a(1, 'h1C), 32'h0083);
    push_exp(3, 16'h0041, 16'h0001);
    push_exp(1, 16'h0083, 16'h0000);
    push_exp(2, 16'h0102, 16'h0000);
    hs_before = hs_count;
    bus_wr(reg_a(3, 'h14), 32'h0001_0000);
    bus_wr(reg_a(3, 'h14), 32'h0101_0000);
    bus_wr(reg_a(2, 'h14), 32'h0001_0000);
    bus_wr(reg_a(2, 'h14), 32'h0101_0000);
    bus_wr(reg_a(1, 'h14), 32'h0001_0000);
    bus_wr(reg_a(1, 'h14), 32'h0101_0000);
    bus_wr(reg_a(3, 'h14), 32'h0);
    rd_chk("R5 ctrl write ignored while busy", reg_a(3, 'h14), 32'h0101_0000);
    rd_chk("R10 stalled set busy", reg_a(3, 'h18), 32'h0);
    rd_chk("R10 queued set busy", reg_a(1, 'h18), 32'h0);
    hold_ready = 1'b0;
    wait_idle(3);
    wait_idle(1);
    wait_idle(2);
    chk("R12 all queued sets drained", 32'(exp_q.size()), 32'h0);
    chk("R5 no extra commands", 32'(hs_count - hs_before), 32'd7);
    rd_chk("R11 only enabled set flagged", reg_a(0, 'h04), 32'h4);

    // R9 status cleared on re-fire
    bus_wr(reg_a(0, 'h1C), 32'h8000);
    bus_wr(reg_a(0, 'h10), 32'h0);
    exp_q.push_back({2'd0, msgid_of(1'b0), addr_of(0, 15), data_of(0, 15)});
    bus_wr(reg_a(0, 'h14), 32'h0001_0000);
    bus_wr(reg_a(0, 'h14), 32'h0101_0000);
    wait_idle(0);
    rd_chk("R9 old slot status cleared", slot_a(0, 0, 'hC), 32'h0);
    rd_chk("R9 old completion cleared", slot_a(0, 2, 'hC), 32'h0);
    rd_chk("R9 last slot issued", slot_a(0, 15, 'hC), 32'h0000_0100);
    rd_chk("R11 second flag set", reg_a(0, 'h04), 32'h5);
    chk("R6 queue empty at end", 32'(exp_q.size()), 32'h0);
    report();
  end
endmodule